// File: doc/BRIEF.md
# Product-Term Sum Slice with Cascade and Foldback

This block is the combinational logic front end of one programmable logic cell. It evaluates five AND terms over a shared input vector. For each term and each input, one mask bit selects the true form of the input and another selects its complement. Each term is then either added to the cell's OR sum or released on a separate output for control use. The OR sum can be widened in two ways. Inverted "foldback" terms from the other cells of a four-cell region can be ORed in, and a cascade input from the neighbouring cell is ORed in as well. The cascaded sum drives a cascade output, so cells can be chained into a long sum.

The last stage is an XOR. One of its inputs is the cascaded sum. The other is a constant 0, a constant 1, a chosen AND term, or a state feedback bit. The constants give polarity control, and the feedback bit lets a following storage element behave as a toggle stage. Every configuration input is static. The region-shared bus is an input, and this cell's own inverted term drives the foldback output.

Top module: `pterm_slice`

## Requirements
- R1: An enabled term is the AND, over all inputs b, of `in_vec[b]` when its true mask bit is set and of `~in_vec[b]` when its complement mask bit is set. An input with neither bit set is ignored. An input with both bits set forces the term to 0. The masks for term i occupy bits `[i*N_IN +: N_IN]` of `true_mask` and `comp_mask`.
- R2: A term whose `term_en` bit is 0 evaluates to 0 and contributes to no output. An enabled term with no mask bits set evaluates to 1.
- R3: When `route_sum[i]` is 1, term i is ORed into `sum_local` and `term_ctl[i]` is 0. When it is 0, term i is left out of the sum and appears on `term_ctl[i]`.
- R4: Every `fold_bus[j]` whose `fold_use[j]` is 1 is ORed into `sum_local`.
- R5: `cas_out` is `sum_local` ORed with `cas_in`.
- R6: `fold_out` is the inverse of term `fold_sel` while `fold_en` is 1. It is 0 while `fold_en` is 0, and it is also 0 when `fold_sel` is 5 or more.
- R7: `xor_out` is `cas_out` XOR a second operand chosen by `xor_mode`: 00 selects 0, 01 selects 1, 10 selects term `xor_term` (0 if `xor_term` is 5 or more), and 11 selects `q_fb`.
- R8: Eight slices chained from `cas_out` to `cas_in` form a single sum of up to 40 terms. A term in any one slice reaches the last slice's `cas_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_vec | input | N_IN | Shared input vector (global and regional signals) |
| term_en | input | 5 | Allocation enable per term |
| true_mask | input | 5*N_IN | True-form select bits, N_IN per term |
| comp_mask | input | 5*N_IN | Complement-form select bits, N_IN per term |
| route_sum | input | 5 | 1 sends the term to the OR sum, 0 releases it |
| fold_bus | input | N_REG | Inverted foldback terms from the region |
| fold_use | input | N_REG | Selects foldback terms to add to the sum |
| fold_en | input | 1 | Enables this cell's foldback output |
| fold_sel | input | 3 | Term index driving the foldback output |
| xor_mode | input | 2 | XOR second-operand select |
| xor_term | input | 3 | Term index used when xor_mode is 10 |
| q_fb | input | 1 | State feedback for toggle emulation |
| cas_in | input | 1 | Cascade sum from the neighbouring cell |
| term_ctl | output | 5 | Terms released for control use |
| sum_local | output | 1 | OR of routed terms and selected foldbacks |
| cas_out | output | 1 | Cascaded sum to the next cell |
| fold_out | output | 1 | Inverted term for the regional bus |
| xor_out | output | 1 | Final XOR result |

## Verification
The bench runs 1500 pseudo-random configurations with a 4-input slice. Each configuration is swept over all 16 input values and compared against an arithmetic model. The sweep separates errors in the true and complement mask positions, in the both-bits and empty-mask cases, and in routing versus release of each term. Directed patterns check the foldback and XOR selectors one by one, including the out-of-range indices. A chain of eight slices is then driven with a single live term placed in each slice in turn, which shows whether the cascade path carries the term to the end of the chain or drops it.

// File: rtl/pterm_slice.sv
module pterm_slice #(
  parameter int N_IN  = 8,
  parameter int N_REG = 4
) (
  input  logic [N_IN-1:0]   in_vec,
  input  logic [4:0]        term_en,
  input  logic [5*N_IN-1:0] true_mask,
  input  logic [5*N_IN-1:0] comp_mask,
  input  logic [4:0]        route_sum,
  input  logic [N_REG-1:0]  fold_bus,
  input  logic [N_REG-1:0]  fold_use,
  input  logic              fold_en,
  input  logic [2:0]        fold_sel,
  input  logic [1:0]        xor_mode,
  input  logic [2:0]        xor_term,
  input  logic              q_fb,
  input  logic              cas_in,
  output logic [4:0]        term_ctl,
  output logic              sum_local,
  output logic              cas_out,
  output logic              fold_out,
  output logic              xor_out
);
  localparam int NT = 5;

  logic [NT-1:0] term;

  for (genvar i = 0; i < NT; i++) begin : g_term
    logic [N_IN-1:0] tm, cm;
    assign tm = true_mask[i*N_IN +: N_IN];
    assign cm = comp_mask[i*N_IN +: N_IN];
    assign term[i] = term_en[i] & (&((~tm | in_vec) & (~cm | ~in_vec)));
  end

  assign term_ctl  = term & ~route_sum;
  assign sum_local = (|(term & route_sum)) | (|(fold_use & fold_bus));
  assign cas_out   = sum_local | cas_in;

  logic fold_src, xor_op, xor_pick;

  always_comb begin
    fold_src = 1'b1;
    if (int'(fold_sel) < NT) fold_src = term[fold_sel];
    xor_pick = 1'b0;
    if (int'(xor_term) < NT) xor_pick = term[xor_term];
    case (xor_mode)
      2'b00:   xor_op = 1'b0;
      2'b01:   xor_op = 1'b1;
      2'b10:   xor_op = xor_pick;
      default: xor_op = q_fb;
    endcase
  end

  assign fold_out = fold_en & ~fold_src;
  assign xor_out  = cas_out ^ xor_op;
endmodule

module pterm_slice_chk #(
  parameter int N_IN  = 8,
  parameter int N_REG = 4
) (
  input logic [4:0]       term_en,
  input logic [4:0]       route_sum,
  input logic [N_REG-1:0] fold_bus,
  input logic [N_REG-1:0] fold_use,
  input logic             fold_en,
  input logic [1:0]       xor_mode,
  input logic             cas_in,
  input logic [4:0]       term_ctl,
  input logic             sum_local,
  input logic             cas_out,
  input logic             fold_out,
  input logic             xor_out
);
  always_comb begin
    a_r3_routed_not_released: assert ((term_ctl & route_sum) == 5'b0);
    if (term_en == 5'b0 && fold_use == '0)
      a_r2_idle_sum_low: assert (!sum_local && term_ctl == 5'b0);
    if ((fold_use & fold_bus) != '0)
      a_r4_fold_sets_sum: assert (sum_local);
    if (cas_in)
      a_r5_cascade_passes: assert (cas_out);
    if (!fold_en)
      a_r6_fold_off: assert (!fold_out);
    if (xor_mode == 2'b00)
      a_r7_zero_polarity: assert (xor_out == cas_out);
    if (xor_mode == 2'b01)
      a_r7_one_polarity: assert (xor_out != cas_out);
  end
endmodule

bind pterm_slice pterm_slice_chk #(.N_IN(N_IN), .N_REG(N_REG)) u_chk (.*);

// File: tb/sim_pterm_slice.sv
module sim_pterm_slice;
  localparam int W = 4;
  localparam int R = 4;
  localparam int NC = 8;

  logic clk = 0;
  always #5 clk = ~clk;

  int tests = 0, fails = 0;
  longint cyc = 0;

  logic [W-1:0]   in_vec;
  logic [4:0]     term_en, route_sum;
  logic [5*W-1:0] true_mask, comp_mask;
  logic [R-1:0]   fold_bus, fold_use;
  logic           fold_en, q_fb, cas_in;
  logic [2:0]     fold_sel, xor_term;
  logic [1:0]     xor_mode;
  logic [4:0]     term_ctl;
  logic           sum_local, cas_out, fold_out, xor_out;

  pterm_slice #(.N_IN(W), .N_REG(R)) u0 (.*);

  logic [W-1:0]   c_in;
  logic [4:0]     c_en   [NC];
  logic [5*W-1:0] c_tm   [NC];
  logic [NC:0]    c_cas;
  assign c_cas[0] = 1'b0;

  for (genvar k = 0; k < NC; k++) begin : g_chain
    logic [4:0] tc;
    logic sl, fo, xo;
    pterm_slice #(.N_IN(W), .N_REG(R)) chain_u (
      .in_vec(c_in), .term_en(c_en[k]), .true_mask(c_tm[k]), .comp_mask('0),
      .route_sum(5'b11111), .fold_bus('0), .fold_use('0), .fold_en(1'b0),
      .fold_sel(3'd0), .xor_mode(2'b00), .xor_term(3'd0), .q_fb(1'b0),
      .cas_in(c_cas[k]), .term_ctl(tc), .sum_local(sl), .cas_out(c_cas[k+1]),
      .fold_out(fo), .xor_out(xo));
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] ref_terms(logic [W-1:0] x, logic [4:0] en,
                                           logic [5*W-1:0] tm, logic [5*W-1:0] cm);
    logic [4:0] t;
    for (int i = 0; i < 5; i++) begin
      logic h = 1'b1;
      for (int b = 0; b < W; b++) begin
        if (tm[i*W+b] && !x[b]) h = 1'b0;
        if (cm[i*W+b] &&  x[b]) h = 1'b0;
      end
      t[i] = en[i] & h;
    end
    return t;
  endfunction

  logic [31:0] seed = 32'h1234_5678;
  function automatic logic [31:0] nxt(logic [31:0] s);
    logic [31:0] v = s;
    v ^= v << 13; v ^= v >> 17; v ^= v << 5;
    return v;
  endfunction

  task automatic compare_all(input string tag);
    logic [4:0] t;
    logic sl, co, fo, xo, op;
    t  = ref_terms(in_vec, term_en, true_mask, comp_mask);
    sl = (|(t & route_sum)) | (|(fold_use & fold_bus));
    co = sl | cas_in;
    fo = fold_en & ((fold_sel < 5) ? ~t[fold_sel] : 1'b0);
    case (xor_mode)
      2'b00: op = 1'b0;
      2'b01: op = 1'b1;
      2'b10: op = (xor_term < 5) ? t[xor_term] : 1'b0;
      default: op = q_fb;
    endcase
    xo = co ^ op;
    check({tag, " R1 R3 term_ctl"}, {3'b0, term_ctl}, {3'b0, t & ~route_sum});
    check({tag, " R3 R4 sum_local"}, {7'b0, sum_local}, {7'b0, sl});
    check({tag, " R5 cas_out"}, {7'b0, cas_out}, {7'b0, co});
    check({tag, " R6 fold_out"}, {7'b0, fold_out}, {7'b0, fo});
    check({tag, " R7 xor_out"}, {7'b0, xor_out}, {7'b0, xo});
  endtask

  task automatic zero_cfg();
    in_vec = '0; term_en = '0; route_sum = '0; true_mask = '0; comp_mask = '0;
    fold_bus = '0; fold_use = '0; fold_en = 0; fold_sel = 0; xor_mode = 0;
    xor_term = 0; q_fb = 0; cas_in = 0;
  endtask

  initial begin
    zero_cfg();
    c_in = '0;
    for (int k = 0; k < NC; k++) begin c_en[k] = '0; c_tm[k] = '0; end
    #2;
    check("R2 idle outputs", {term_ctl, sum_local, cas_out, fold_out}, 8'h0);

    // R2: enabled empty-mask term is 1, disabled is 0
    term_en = 5'b00001; route_sum = 5'b00001; #2;
    check("R2 empty mask enabled", {7'b0, sum_local}, 8'h1);
    term_en = 5'b0; #2;
    check("R2 disabled term", {7'b0, sum_local}, 8'h0);

    // R1: both mask bits on one input force 0
    term_en = 5'b00001; true_mask[0] = 1; comp_mask[0] = 1;
    for (int v = 0; v < 2; v++) begin
      in_vec = W'(v); #2;
      check("R1 both bits zero", {7'b0, sum_local}, 8'h0);
    end
    zero_cfg();

    // R6: fold_sel out of range; R7: xor_term out of range
    term_en = 5'b11111; fold_en = 1; xor_mode = 2'b10;
    for (int s = 5; s < 8; s++) begin
      fold_sel = 3'(s); xor_term = 3'(s); #2;
      check("R6 fold_sel range", {7'b0, fold_out}, 8'h0);
      check("R7 xor_term range", {7'b0, xor_out}, 8'h0);
    end
    // R7: toggle via q_fb
    xor_mode = 2'b11; q_fb = 1; #2;
    check("R7 toggle q_fb", {7'b0, xor_out}, 8'h1);
    cas_in = 1; #2;
    check("R5 R7 cas and q_fb", {6'b0, cas_out, xor_out}, 8'h2);
    zero_cfg();

    // Randomised configurations swept over every input value
    for (int n = 0; n < 1500; n++) begin
      seed = nxt(seed); term_en = seed[4:0]; route_sum = seed[9:5];
      fold_bus = seed[13:10]; fold_use = seed[17:14]; fold_en = seed[18];
      fold_sel = seed[21:19]; xor_mode = seed[23:22]; xor_term = seed[26:24];
      q_fb = seed[27]; cas_in = (seed[31:28] == 4'h0);
      seed = nxt(seed); true_mask = seed[5*W-1:0];
      seed = nxt(seed); comp_mask = seed[5*W-1:0] & seed[31:32-5*W];
      if (n % 4 == 0) fold_use = '0;
      for (int v = 0; v < (1 << W); v++) begin
        in_vec = W'(v); #2;
        compare_all("sweep");
      end
    end
    zero_cfg();

    // R8: one live term in each slice reaches the chain end
    for (int k = 0; k < NC; k++) begin
      for (int j = 0; j < NC; j++) begin c_en[j] = '0; c_tm[j] = '0; end
      c_en[k] = 5'b00001 << (k % 5);
      c_tm[k] = (5*W)'(1) << ((k % 5)*W + (k % W));
      c_in = '0; #2;
      check("R8 chain low", {7'b0, c_cas[NC]}, 8'h0);
      c_in = W'(1) << (k % W); #2;
      check("R8 chain high", {7'b0, c_cas[NC]}, 8'h1);
    end
    // R8: all 40 terms on the chain, input pattern 0 hits none, any 1 hits
    for (int j = 0; j < NC; j++) begin
      c_en[j] = 5'b11111;
      for (int i = 0; i < 5; i++) c_tm[j][i*W +: W] = W'(1) << ((i + j) % W);
    end
    for (int v = 0; v < (1 << W); v++) begin
      c_in = W'(v); #2;
      check("R8 forty terms", {7'b0, c_cas[NC]}, {7'b0, (v != 0)});
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule